// File: doc/BRIEF.md
# Free-Running Timer with Byte-Wise Access

This block is a 16-bit up-counter that a small processor reaches over an 8-bit register bus. The counter advances on pulses from one of two sources: a half-rate copy of the system clock or an external slow oscillator. Whichever source is chosen passes through a two-flop synchroniser and a rising-edge detector, so every source edge becomes one single-cycle pulse in the system clock domain. A power-of-two prescaler then thins those pulses before they reach the counter.

Software sees the 16-bit count as two byte registers. Touching the high byte, by reading or writing it, freezes the counter until the low byte is touched. A read of the high byte also copies the live low byte into a snapshot register, so the two bytes always form one coherent 16-bit value. When the count rolls over from its top value to zero, an overflow flag is set. That flag drives an interrupt request when both the overflow enable and the global enable are set.

Top module: `free_run_timer`

## Requirements
- R1: After reset the count, the snapshot, the overflow flag and every control bit read as zero, and `irq` is low.
- R2: With source select 0 and prescale 0, the counter advances by exactly one for every two system cycles in which it runs.
- R3: With source select 1 (bit 0 at 0x94), each rising edge of `slow_clk` advances the counter by exactly one, provided each level is held for at least three system cycles.
- R4: A prescale code p in bits 3:1 at 0x94 makes the counter advance once per 2^p synchronised pulses. The prescaler restarts from zero whenever the counter is disabled.
- R5: While bit 0 at 0x80 (enable) is 0, the count does not change.
- R6: A read or write of 0x1B stops counting from that same cycle until the next read or write of 0x1A. A read of 0x1B copies the current low byte into the snapshot at 0x1C.
- R7: Reads of 0x1A alone do not disturb counting.
- R8: A write to 0x1B loads the high count byte and a write to 0x1A loads the low count byte. Both are read back at the same addresses.
- R9: A rollover from 0xFFFF to 0x0000 sets bit 0 at 0x11. Writing 0 to that bit clears it, and writing 1 leaves it unchanged.
- R10: `irq` is high exactly when the overflow flag, bit 0 at 0x81 (overflow enable) and bit 7 at 0x81 (global enable) are all 1.
- R11: Each rising edge of the selected source produces exactly one single-cycle count pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| slow_clk | input | 1 | Asynchronous slow oscillator input |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Overflow interrupt request |

## Verification
The counter is run through enable windows of exact even length for every prescale code. The expected count is computed as the pulse count shifted right by the code, which shows whether the divide ratio and the prescaler restart are both right.

A second window interleaves low-byte reads with idle cycles, and a third starts with a high-byte read. The first must give the full count and the second must freeze for a while and then resume, which separates the low and high access paths. Slow-source edges driven one at a time show whether the synchroniser turns each edge into exactly one pulse. A start value just below the top shows rollover, and the set, clear and masking of the flag and the interrupt.

// File: rtl/frt_pkg.sv
package frt_pkg;

  // True when the prescaler count has reached the last pulse of a 2^sel group.
  function automatic logic presc_hit(input int unsigned pre, input int unsigned sel);
    int unsigned msk;
    msk = (32'd1 << sel) - 32'd1;
    return (pre & msk) == msk;
  endfunction

  // True when a w-bit value holds its all-ones top value.
  function automatic logic is_top(input logic [63:0] v, input int unsigned w);
    return v == ((64'd1 << w) - 64'd1);
  endfunction

endpackage

// File: rtl/frt_tick_sync.sv
module frt_tick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic slow_clk,
  output logic tick
);
  logic              half_q;
  logic              src_raw;
  logic [SYNC_STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  assign src_raw = src_sel ? slow_clk : half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC_STAGES-1:0], src_raw};
  end

  // One pulse per rising edge after the synchroniser stages.
  assign tick = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/frt_prescale.sv
module frt_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [SEL_W-1:0] sel,
  output logic             step
);
  localparam int PRE_W = (1 << SEL_W) - 1;
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (adv) pre_q <= pre_q + 1'b1;
  end

  assign step = adv && frt_pkg::presc_hit(32'(pre_q), 32'(sel));
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic                rd_hi,
  input  logic                acc_lo,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] count,
  output logic [DATA_W-1:0]   lo_snap,
  output logic                hold,
  output logic                wrap
);
  localparam int CNT_W = 2 * DATA_W;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] snap_q;
  logic              hold_q;
  logic              any_wr;

  assign any_wr = wr_lo | wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (any_wr) begin
      if (wr_lo) cnt_q[DATA_W-1:0]     <= wdata;
      if (wr_hi) cnt_q[CNT_W-1:DATA_W] <= wdata;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold_q <= 1'b0;
    else if (wr_hi || rd_hi)   hold_q <= 1'b1;
    else if (acc_lo)           hold_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap_q <= '0;
    else if (rd_hi) snap_q <= cnt_q[DATA_W-1:0];
  end

  assign wrap    = step && !any_wr && frt_pkg::is_top(64'(cnt_q), CNT_W);
  assign count   = cnt_q;
  assign lo_snap = snap_q;
  assign hold    = hold_q;

  assert_count_plus_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !any_wr) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_hold_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !any_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/free_run_timer.sv
module free_run_timer #(
  parameter int          DATA_W      = 8,
  parameter int          PRE_SEL_W   = 3,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  ADDR_FLAG   = 8'h11,
  parameter logic [7:0]  ADDR_LO     = 8'h1A,
  parameter logic [7:0]  ADDR_HI     = 8'h1B,
  parameter logic [7:0]  ADDR_SNAP   = 8'h1C,
  parameter logic [7:0]  ADDR_EN     = 8'h80,
  parameter logic [7:0]  ADDR_IE     = 8'h81,
  parameter logic [7:0]  ADDR_CTRL   = 8'h94
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W   = 2 * DATA_W;
  localparam int GIE_BIT = DATA_W - 1;

  logic                 en_q, src_q, ovf_ie_q, gie_q, ovf_flag_q;
  logic [PRE_SEL_W-1:0] psel_q;
  logic                 sel_flag, sel_lo, sel_hi, sel_snap, sel_en, sel_ie, sel_ctrl;
  logic                 wr_lo, wr_hi, rd_hi, acc_lo, clr_flag;
  logic                 tick, step, run, wrap, hold;
  logic [CNT_W-1:0]     count;
  logic [DATA_W-1:0]    lo_snap;

  assign sel_flag = bus_addr == ADDR_FLAG;
  assign sel_lo   = bus_addr == ADDR_LO;
  assign sel_hi   = bus_addr == ADDR_HI;
  assign sel_snap = bus_addr == ADDR_SNAP;
  assign sel_en   = bus_addr == ADDR_EN;
  assign sel_ie   = bus_addr == ADDR_IE;
  assign sel_ctrl = bus_addr == ADDR_CTRL;

  assign wr_lo    = bus_wr && sel_lo;
  assign wr_hi    = bus_wr && sel_hi;
  assign rd_hi    = bus_rd && sel_hi;
  assign acc_lo   = (bus_wr || bus_rd) && sel_lo;
  assign clr_flag = bus_wr && sel_flag && !bus_wdata[0];

  // Counting stops in the very cycle of a high-byte access.
  assign run = en_q && !hold && !(wr_hi || rd_hi);

  frt_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .src_sel(src_q), .slow_clk(slow_clk), .tick(tick)
  );

  frt_prescale #(.SEL_W(PRE_SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(!en_q), .adv(tick && run), .sel(psel_q), .step(step)
  );

  frt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .rd_hi(rd_hi), .acc_lo(acc_lo), .wdata(bus_wdata), .count(count),
    .lo_snap(lo_snap), .hold(hold), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      src_q    <= 1'b0;
      psel_q   <= '0;
      ovf_ie_q <= 1'b0;
      gie_q    <= 1'b0;
    end else if (bus_wr) begin
      if (sel_en) en_q <= bus_wdata[0];
      if (sel_ie) begin
        ovf_ie_q <= bus_wdata[0];
        gie_q    <= bus_wdata[GIE_BIT];
      end
      if (sel_ctrl) begin
        src_q  <= bus_wdata[0];
        psel_q <= bus_wdata[PRE_SEL_W:1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_flag_q <= 1'b0;
    else if (wrap)     ovf_flag_q <= 1'b1;
    else if (clr_flag) ovf_flag_q <= 1'b0;
  end

  assign irq = ovf_flag_q && ovf_ie_q && gie_q;

  always_comb begin
    bus_rdata = '0;
    if (sel_flag)      bus_rdata[0] = ovf_flag_q;
    else if (sel_lo)   bus_rdata = count[DATA_W-1:0];
    else if (sel_hi)   bus_rdata = count[CNT_W-1:DATA_W];
    else if (sel_snap) bus_rdata = lo_snap;
    else if (sel_en)   bus_rdata[0] = en_q;
    else if (sel_ie) begin
      bus_rdata[0]       = ovf_ie_q;
      bus_rdata[GIE_BIT] = gie_q;
    end else if (sel_ctrl) begin
      bus_rdata[0]           = src_q;
      bus_rdata[PRE_SEL_W:1] = psel_q;
    end
  end

  assert_step_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> tick);

  assert_disabled_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_lo && !wr_hi) |=> $stable(count));

  assert_wrap_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag_q);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag && !wrap) |=> !ovf_flag_q);
endmodule

// File: tb/free_run_timer_test.sv
`timescale 1ns/1ps
module free_run_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_clk = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  free_run_timer uut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set16(input logic [15:0] v);
    wr(8'h1B, v[15:8]);
    wr(8'h1A, v[7:0]);
  endtask

  task automatic get16(output logic [15:0] v);
    logic [7:0] h, l, x;
    rd(8'h1B, h);
    rd(8'h1C, l);
    rd(8'h1A, x);
    v = {h, l};
  endtask

  // Enable for exactly 2*k running edges: k half-rate pulses.
  task automatic run_window(input int k);
    wr(8'h80, 8'h01);
    repeat (2 * k - 1) @(negedge clk);
    wr(8'h80, 8'h00);
  endtask

  function automatic int exp_steps(input int pulses, input int p);
    return pulses / (1 << p);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d, h, b, prev;
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    get16(v);           check("R1 count", 32'(v), 32'h0);
    rd(8'h11, d);       check("R1 flag", 32'(d), 32'h0);
    rd(8'h80, d);       check("R1 enable", 32'(d), 32'h0);
    rd(8'h81, d);       check("R1 int enables", 32'(d), 32'h0);
    rd(8'h94, d);       check("R1 control", 32'(d), 32'h0);
    #1 check("R1 irq", 32'(irq), 32'h0);

    // R8: write and read back both bytes
    set16(16'hA55A);
    rd(8'h1B, d);       check("R8 high byte", 32'(d), 32'hA5);
    rd(8'h1A, d);       check("R8 low byte", 32'(d), 32'h5A);

    // R5: disabled counter stays put
    repeat (100) @(negedge clk);
    get16(v);           check("R5 disabled count", 32'(v), 32'hA55A);

    // R2, R4: every prescale code over a 300-pulse window
    for (int p = 0; p < 8; p++) begin
      wr(8'h94, 8'(p << 1));
      set16(16'h0000);
      run_window(300);
      get16(v);
      check($sformatf("R4 R2 prescale %0d", p), 32'(v), 32'(exp_steps(300, p)));
    end
    wr(8'h94, 8'h00);

    // R6: high-byte read freezes and snapshots, low access resumes
    set16(16'h0000);
    wr(8'h80, 8'h01);
    repeat (20) @(negedge clk);
    rd(8'h1B, h);       check("R6 high at freeze", 32'(h), 32'h0);
    repeat (30) @(negedge clk);
    rd(8'h1C, b);       check("R6 snapshot", 32'(b), 32'd10);
    rd(8'h1B, h);       check("R6 still frozen high", 32'(h), 32'h0);
    rd(8'h1A, d);       check("R6 frozen low", 32'(d), 32'd10);
    repeat (19) @(negedge clk);
    wr(8'h80, 8'h00);
    get16(v);           check("R6 resumed count", 32'(v), 32'd20);

    // R7: low-only reads do not disturb counting
    set16(16'h0000);
    wr(8'h80, 8'h01);
    prev = 8'h00;
    for (int i = 0; i < 6; i++) begin
      repeat (4) @(negedge clk);
      rd(8'h1A, d);
      check("R7 low read monotonic", 32'(d >= prev), 32'h1);
      prev = d;
    end
    repeat (9) @(negedge clk);
    wr(8'h80, 8'h00);
    get16(v);           check("R7 full count", 32'(v), 32'd20);

    // R3, R11: slow source, one count per rising edge
    wr(8'h94, 8'h01);
    set16(16'h0000);
    repeat (6) @(negedge clk);
    wr(8'h80, 8'h01);
    for (int i = 0; i < 7; i++) begin
      slow_clk = 1'b1; repeat (4) @(negedge clk);
      slow_clk = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    wr(8'h80, 8'h00);
    get16(v);           check("R3 R11 slow edges", 32'(v), 32'd7);
    wr(8'h94, 8'h00);

    // R9: rollover sets the flag
    set16(16'hFFFD);
    run_window(5);
    get16(v);           check("R9 wrapped count", 32'(v), 32'h0002);
    rd(8'h11, d);       check("R9 flag set", 32'(d), 32'h1);

    // R10: interrupt gating
    wr(8'h81, 8'h01);   #1 check("R10 no global", 32'(irq), 32'h0);
    wr(8'h81, 8'h80);   #1 check("R10 no source enable", 32'(irq), 32'h0);
    wr(8'h81, 8'h81);   #1 check("R10 all set", 32'(irq), 32'h1);

    // R9: writing 1 keeps, writing 0 clears
    wr(8'h11, 8'hFF);
    rd(8'h11, d);       check("R9 write one keeps", 32'(d), 32'h1);
    wr(8'h11, 8'h00);
    rd(8'h11, d);       check("R9 write zero clears", 32'(d), 32'h0);
    #1 check("R10 cleared flag", 32'(irq), 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule